// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block watches the sample-rate frame clock from inside the master clock domain and works out on its own whether the master clock runs at 256, 384 or 512 times the sample rate. No pin or register selects the ratio. Once the ratio is known, the block produces a clock-enable strobe that thins the master clock down to an effective 256 times the sample rate. It does this by skipping master cycles rather than by making a new clock.

The frame clock is brought into the master domain through a short synchronizer. The block counts master cycles between successive rising edges of the synchronized frame clock. A count is accepted only when two back-to-back frames agree on one of the three legal lengths. The master clock must be frequency-locked to the frame clock, but their relative phase and the frame clock duty cycle play no part.

Any frame whose length matches none of the three ratios drops the lock at once. So does a frame that jumps to a different legal ratio. While the lock is down, the strobe stays low and its phase counter returns to its starting point.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `locked_o` is 0, `ratio_o` is 0 and `ce_o` is 0.
- R2: Frame length is the number of master cycles between two rising edges of the synchronized frame clock. `ratio_o` encodes it as 1 for BASE_RATIO, 2 for 3/2·BASE_RATIO, 3 for 2·BASE_RATIO and 0 for no ratio. `ratio_o` changes only in response to a completed measurement.
- R3: `locked_o` rises only after two consecutive measured frames have the same legal length. The first rising edge after reset yields no measurement.
- R4: When locked at code 1, `ce_o` is high on every master cycle.
- R5: When locked at code 2, `ce_o` is high on two of every three master cycles. It is never high three cycles running and never low two cycles running.
- R6: When locked at code 3, `ce_o` alternates, high on every other master cycle.
- R7: A measured length that matches no legal ratio clears `locked_o`, sets `ratio_o` to 0 and holds `ce_o` low. This includes a one-cycle near miss and a frame longer than the counter range.
- R8: A measurement of a legal ratio that differs from the previous measurement clears the lock. Lock returns only when the new ratio is seen in two consecutive frames.
- R9: The frame clock duty cycle and its phase against the master clock have no effect on the detected ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lrck_i | input | 1 | Frame clock, asynchronous to this domain |
| ratio_o | output | 2 | Detected ratio code (0 none, 1/2/3 as in R2) |
| locked_o | output | 1 | Ratio qualified by two matching frames |
| ce_o | output | 1 | Enable strobe at 256 times the sample rate |

## Verification
The bench builds the block with BASE_RATIO set to 16, so legal frames are 16, 24 and 32 master cycles long. This makes each frame short enough that dozens of lock, unlock and ratio-change sequences fit into a short run. At this size, near-miss lengths one cycle off each legal value are easy to reach, and so is a frame long enough to saturate the period counter. The frame clock duty cycle is randomized on every frame, and a bench model of the two-frame rule predicts lock and ratio at the end of each frame.

// File: rtl/mcrd_pkg.sv
package mcrd_pkg;
  typedef enum logic [1:0] {
    RATIO_NONE = 2'd0,
    RATIO_X1   = 2'd1,
    RATIO_X15  = 2'd2,
    RATIO_X2   = 2'd3
  } ratio_e;
endpackage

// File: rtl/mcrd_sync.sv
module mcrd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/mcrd_period_meas.sv
module mcrd_period_meas #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lvl_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise = lvl_i & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q      <= 1'b0;
      seen_q     <= 1'b0;
      cnt_q      <= '0;
      meas_vld_o <= 1'b0;
      meas_cnt_o <= '0;
    end else begin
      lvl_q <= lvl_i;
      if (rise) begin
        cnt_q      <= CNT_W'(1);
        seen_q     <= 1'b1;
        meas_vld_o <= seen_q;   // first edge only starts the count
        meas_cnt_o <= cnt_q;
      end else begin
        meas_vld_o <= 1'b0;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mcrd_ratio_qual.sv
module mcrd_ratio_qual
  import mcrd_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int BASE_RATIO = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_vld_i,
  input  logic [CNT_W-1:0] meas_cnt_i,
  output logic             locked_o,
  output ratio_e           ratio_o
);
  localparam logic [CNT_W-1:0] LEN_X1  = CNT_W'(BASE_RATIO);
  localparam logic [CNT_W-1:0] LEN_X15 = CNT_W'(BASE_RATIO * 3 / 2);
  localparam logic [CNT_W-1:0] LEN_X2  = CNT_W'(BASE_RATIO * 2);

  ratio_e cls;
  ratio_e prev_q;

  always_comb begin
    cls = RATIO_NONE;
    if (meas_cnt_i == LEN_X1)       cls = RATIO_X1;
    else if (meas_cnt_i == LEN_X15) cls = RATIO_X15;
    else if (meas_cnt_i == LEN_X2)  cls = RATIO_X2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= RATIO_NONE;
      locked_o <= 1'b0;
      ratio_o  <= RATIO_NONE;
    end else if (meas_vld_i) begin
      prev_q <= cls;
      if (cls != RATIO_NONE && cls == prev_q) begin
        locked_o <= 1'b1;
        ratio_o  <= cls;
      end else begin
        locked_o <= 1'b0;
        ratio_o  <= RATIO_NONE;
      end
    end
  end
endmodule

// File: rtl/mcrd_ce_gen.sv
module mcrd_ce_gen
  import mcrd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   locked_i,
  input  ratio_e ratio_i,
  output logic   ce_o
);
  logic [1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= 2'd0;
    end else if (!locked_i) begin
      ph_q <= 2'd0;
    end else begin
      unique case (ratio_i)
        RATIO_X15: ph_q <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
        RATIO_X2:  ph_q <= {1'b0, ~ph_q[0]};
        default:   ph_q <= 2'd0;
      endcase
    end
  end

  always_comb begin
    ce_o = 1'b0;
    if (locked_i) begin
      unique case (ratio_i)
        RATIO_X1:  ce_o = 1'b1;
        RATIO_X15: ce_o = (ph_q != 2'd2);
        RATIO_X2:  ce_o = (ph_q == 2'd0);
        default:   ce_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mcrd_pkg::*;
#(
  parameter int BASE_RATIO  = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lrck_i,
  output logic [1:0] ratio_o,
  output logic       locked_o,
  output logic       ce_o
);
  // two spare bits so the count saturates well past the longest legal frame
  localparam int CNT_W = $clog2(2 * BASE_RATIO) + 2;

  logic             lrck_s;
  logic             meas_vld;
  logic [CNT_W-1:0] meas_cnt;
  ratio_e           ratio;

  mcrd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lrck_i),
    .q_o    (lrck_s)
  );

  mcrd_period_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (lrck_s),
    .meas_vld_o (meas_vld),
    .meas_cnt_o (meas_cnt)
  );

  mcrd_ratio_qual #(.CNT_W(CNT_W), .BASE_RATIO(BASE_RATIO)) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .meas_vld_i (meas_vld),
    .meas_cnt_i (meas_cnt),
    .locked_o   (locked_o),
    .ratio_o    (ratio)
  );

  mcrd_ce_gen u_ce (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .locked_i (locked_o),
    .ratio_i  (ratio),
    .ce_o     (ce_o)
  );

  assign ratio_o = ratio;
endmodule

// File: rtl/mcrd_chk.sv
module mcrd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       locked_i,
  input logic [1:0] ratio_i,
  input logic       ce_i,
  input logic       meas_vld_i
);
  logic is_x15, is_x2;
  assign is_x15 = locked_i && ratio_i == 2'd2;
  assign is_x2  = locked_i && ratio_i == 2'd3;

  // R2
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(meas_vld_i) |-> $stable(ratio_i));

  // R3
  lock_on_meas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i != $past(locked_i)) |-> $past(meas_vld_i));

  // R4
  x1_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && ratio_i == 2'd1) |-> ce_i);

  // R5
  x15_no_triple_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_x15 && $past(is_x15) && $past(is_x15, 2)) |-> !(ce_i && $past(ce_i) && $past(ce_i, 2)));

  // R5
  x15_no_double_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_x15 && $past(is_x15)) |-> (ce_i || $past(ce_i)));

  // R6
  x2_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_x2 && $past(is_x2)) |-> (ce_i != $past(ce_i)));

  // R7
  unlocked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |-> (!ce_i && ratio_i == 2'd0));
endmodule

bind mclk_ratio_detect mcrd_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .locked_i   (locked_o),
  .ratio_i    (ratio_o),
  .ce_i       (ce_o),
  .meas_vld_i (meas_vld)
);

// File: tb/mclk_ratio_detect_tb.sv
`timescale 1ns/1ps
module mclk_ratio_detect_tb;
  localparam int B = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrck = 1'b0;
  logic [1:0] ratio;
  logic       locked;
  logic       ce;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state: last two measured frame lengths
  int m_old = -1, m_new = -2, prev_len = 0, n_meas = 0;
  bit started = 0;

  always #10 clk = ~clk;

  mclk_ratio_detect #(.BASE_RATIO(B)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lrck_i(lrck),
    .ratio_o(ratio), .locked_o(locked), .ce_o(ce)
  );

  function automatic int cls_of(int len);
    if (len == B)         return 1;
    if (len == B * 3 / 2) return 2;
    if (len == 2 * B)     return 3;
    return 0;
  endfunction

  function automatic int ce_in6(int code);
    case (code)
      1: return 6;
      2: return 4;
      3: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one frame of len cycles with random high time
  task automatic frame(int len, string tag);
    int h = 1 + int'($urandom % (len - 1));
    int ce_cnt = 0;
    int exp_code;
    bit exp_lock;
    if (started) begin
      m_old = m_new;
      m_new = prev_len;
      n_meas++;
    end
    started = 1;
    prev_len = len;
    exp_lock = (n_meas >= 2) && (m_old == m_new) && (cls_of(m_new) != 0);
    exp_code = exp_lock ? cls_of(m_new) : 0;
    for (int c = 0; c < len; c++) begin
      @(posedge clk); #1;
      lrck = (c < h);
      @(negedge clk);
      if (c >= len - 6) ce_cnt += int'(ce);
    end
    check(tag, int'(locked), int'(exp_lock), "R3 locked");
    check(tag, int'(ratio), exp_code, "R2 ratio code");
    if (len >= 12) begin
      case (exp_code)
        1: check("R4", ce_cnt, 6, "ce count in 6 cycles");
        2: check("R5", ce_cnt, 4, "ce count in 6 cycles");
        3: check("R6", ce_cnt, 3, "ce count in 6 cycles");
        default: check("R7", ce_cnt, 0, "ce count in 6 cycles");
      endcase
    end
  endtask

  task automatic frames(int len, int n, string tag);
    for (int i = 0; i < n; i++) frame(len, tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", int'(locked), 0, "locked in reset");
    check("R1", int'(ratio), 0, "ratio in reset");
    check("R1", int'(ce), 0, "ce in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'(locked) + int'(ratio) + int'(ce), 0, "outputs after release");

    frames(B, 4, "R3");
    frames(B * 3 / 2, 4, "R8");
    frames(2 * B, 4, "R8");
    frames(B + 1, 1, "R7");
    frames(2 * B, 3, "R3");
    frames(2 * B - 1, 1, "R7");
    frames(B * 3 / 2, 3, "R8");
    frames(B * 3 / 2 + 1, 1, "R7");
    frames(B, 3, "R8");
    frames(200, 1, "R7");
    frames(B, 3, "R3");
    frames(B - 1, 1, "R7");

    for (int g = 0; g < 60; g++) begin
      int pick = int'($urandom % 4);
      int n = 1 + int'($urandom % 4);
      int len;
      case (pick)
        0: len = B;
        1: len = B * 3 / 2;
        2: len = 2 * B;
        default: begin
          len = 6 + int'($urandom % 40);
          if (cls_of(len) != 0) len = len + 1;
        end
      endcase
      frames(len, n, "R9");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule